// File: doc/BRIEF.md
# Half-Duplex Backpressure Jam Generator

This block sits on the nibble-wide MII transmit path of a half-duplex Ethernet port. When software sets the backpressure enable, the block sends a repeating train of jam bursts. Remote stations see carrier on the shared medium and defer, so the port can hold off incoming traffic without dropping frames.

Each burst drives the fixed alternating nibble 4'b0101 with TxEn high for a programmed number of nibble times. Bursts are separated by a programmed quiet gap. The same gap is also required after the normal transmitter's last frame before the first burst.

While no burst is active, the normal transmitter's TxEn and TxD pass straight through to the MII. The block never jams while the port is in full-duplex mode.

Top module: `bp_jam_gen`

## Requirements
- R1: After reset with `bp_enable` low, `jam_active` and `mii_tx_en` are low.
- R2: Whenever `jam_active` is low, `mii_tx_en` equals `norm_tx_en` and `mii_txd` equals `norm_txd` in the same cycle.
- R3: Suppose the block is idle and a rising edge samples `bp_enable` and `half_duplex` both high. `mii_tx_en` then stays low for exactly max(G,1) further cycles (G = `jam_gap`) before the first burst, provided `norm_tx_en` stays low.
- R4: During a burst, `jam_active` and `mii_tx_en` are high and `mii_txd` is 4'b0101. A burst lasts exactly max(L,1) cycles, where L = `jam_len`.
- R5: While the enable stays set, consecutive bursts are separated by exactly max(G,1) cycles with `mii_tx_en` low.
- R6: A programmed value of zero for either `jam_len` or `jam_gap` behaves as one nibble time.
- R7: No burst begins at a clock edge that samples `norm_tx_en` high. While the gap is pending, each such edge restarts the gap count. The first burst therefore starts max(G,1) cycles after the last cycle with `norm_tx_en` high.
- R8: Clearing `bp_enable` during a burst lets that burst run to its full length, after which the block goes idle. Clearing it during a gap prevents any further burst.
- R9: While `half_duplex` is low, `jam_active` is low and the MII carries the normal transmitter's signals. A burst in progress stops in the same cycle and does not resume. When half duplex returns, the sequence starts again with a full gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_enable | input | 1 | Software backpressure enable |
| half_duplex | input | 1 | High when the port runs half duplex |
| jam_len | input | CNT_W | Burst length in nibble times (0 means 1) |
| jam_gap | input | CNT_W | Gap length in nibble times (0 means 1) |
| norm_tx_en | input | 1 | TxEn from the normal frame transmitter |
| norm_txd | input | NIB_W | TxD from the normal frame transmitter |
| mii_tx_en | output | 1 | MII transmit enable |
| mii_txd | output | NIB_W | MII transmit data nibble |
| jam_active | output | 1 | High while a jam burst is being driven |

## Verification
Random length and gap pairs from 0 to 6 are enabled from idle, and the enable is dropped at a random cycle. The resulting trace shows whether the off-by-one in the gap or burst counting is right, whether zero is clamped, and whether a drop completes the current burst or cuts it short. A directed run holds the normal transmitter busy, both before the first burst and in the middle of an inter-burst gap, to show that the gap count restarts from the transmitter's falling edge. Full-duplex runs, including a drop of half duplex mid-burst, separate gated output from a burst that silently resumes. A 300-nibble burst checks that long counts are not truncated.

// File: rtl/bp_jam_gen.sv
module bp_jam_gen #(
  parameter int CNT_W = 16,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bp_enable,
  input  logic             half_duplex,
  input  logic [CNT_W-1:0] jam_len,
  input  logic [CNT_W-1:0] jam_gap,
  input  logic             norm_tx_en,
  input  logic [NIB_W-1:0] norm_txd,
  output logic             mii_tx_en,
  output logic [NIB_W-1:0] mii_txd,
  output logic             jam_active
);
  localparam logic [NIB_W-1:0] JAM_PAT = {(NIB_W/2){2'b01}};

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_BURST} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;

  wire              arm    = bp_enable && half_duplex;
  wire [CNT_W-1:0]  gap_ld = (jam_gap == '0) ? '0 : jam_gap - 1'b1;
  wire [CNT_W-1:0]  len_ld = (jam_len == '0) ? '0 : jam_len - 1'b1;
  wire              done   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (arm) begin
          st  <= S_GAP;
          cnt <= gap_ld;
        end
        S_GAP: begin
          if (!arm)
            st <= S_IDLE;
          else if (norm_tx_en)
            cnt <= gap_ld;
          else if (done) begin
            st  <= S_BURST;
            cnt <= len_ld;
          end else
            cnt <= cnt - 1'b1;
        end
        S_BURST: begin
          if (!half_duplex)
            st <= S_IDLE;
          else if (done) begin
            if (bp_enable) begin
              st  <= S_GAP;
              cnt <= gap_ld;
            end else
              st <= S_IDLE;
          end else
            cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign jam_active = (st == S_BURST) && half_duplex;
  assign mii_tx_en  = jam_active ? 1'b1 : norm_tx_en;
  assign mii_txd    = jam_active ? JAM_PAT : norm_txd;
endmodule

// File: rtl/bp_jam_gen_chk.sv
module bp_jam_gen_chk #(
  parameter int CNT_W = 16,
  parameter int NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bp_enable,
  input logic             half_duplex,
  input logic [CNT_W-1:0] jam_len,
  input logic             norm_tx_en,
  input logic             mii_tx_en,
  input logic [NIB_W-1:0] mii_txd,
  input logic             jam_active
);
  localparam logic [NIB_W-1:0] JAM_PAT = {(NIB_W/2){2'b01}};

  logic [CNT_W:0] run;
  wire  [CNT_W:0] len_eff = (jam_len == '0) ? 1 : {1'b0, jam_len};

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else        run <= jam_active ? run + 1'b1 : '0;
  end

  assert_jam_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    jam_active |-> (mii_tx_en && mii_txd == JAM_PAT));

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!jam_active && $past(jam_active) && half_duplex && $past(half_duplex)) |-> (run == len_eff));

  assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> $past(!norm_tx_en));

  assert_start_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> $past(bp_enable));

  assert_full_duplex_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !half_duplex |-> (!jam_active && mii_tx_en == norm_tx_en));
endmodule

bind bp_jam_gen bp_jam_gen_chk #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bp_enable(bp_enable), .half_duplex(half_duplex),
  .jam_len(jam_len), .norm_tx_en(norm_tx_en), .mii_tx_en(mii_tx_en),
  .mii_txd(mii_txd), .jam_active(jam_active)
);

// File: tb/tb_bp_jam_gen.sv
`timescale 1ns/1ps
module tb_bp_jam_gen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bp_enable = 0, half_duplex = 0, norm_tx_en = 0;
  logic [15:0] jam_len = 0, jam_gap = 0;
  logic [3:0]  norm_txd = 0;
  logic        mii_tx_en, jam_active;
  logic [3:0]  mii_txd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bp_jam_gen dut (.*);

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit pattern_jam(input int i, input int g, input int l);
    return (i >= 1) && (((i - 1) % (eff(g) + eff(l))) >= eff(g));
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check1(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_trace(input int g, input int l, input int ncyc, input int drop, input string req);
    int bad = 0;
    bit alive = 1, pat, ex;
    logic [3:0] extxd;
    jam_gap = g[15:0]; jam_len = l[15:0];
    half_duplex = 1; norm_tx_en = 0; bp_enable = 1;
    for (int i = 0; i < ncyc; i++) begin
      if (i == drop) bp_enable = 0;
      norm_txd = 4'($urandom_range(0, 15));
      @(negedge clk);
      pat = pattern_jam(i, g, l);
      if (i >= drop && !pat) alive = 0;
      ex = pat && (i < drop || alive);
      extxd = ex ? 4'h5 : norm_txd;
      if (bad == 0 && (jam_active !== ex || mii_tx_en !== ex || mii_txd !== extxd)) begin
        bad = 1;
        $display("FAIL %s g=%0d l=%0d cycle %0d: actual jam=%b en=%b txd=%h expected jam=%b en=%b txd=%h",
                 req, g, l, i, jam_active, mii_tx_en, mii_txd, ex, ex, extxd);
      end
      tick();
    end
    bp_enable = 0;
    repeat (eff(g) + eff(l) + 4) tick();
    checks++;
    if (bad) errors++;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) tick();
    @(negedge clk);
    check1(!jam_active && !mii_tx_en, "R1 in reset", {jam_active, mii_tx_en}, 0);
    rst_n = 1;
    tick(); tick();
    @(negedge clk);
    check1(!jam_active && !mii_tx_en, "R1 after reset", {jam_active, mii_tx_en}, 0);
    tick();

    // R6: zero length and gap clamp to one
    run_trace(0, 0, 14, 14, "R6 R3 R4 R5");
    // long burst, no truncation
    run_trace(2, 300, 310, 5, "R4 long R8");
    // drop during a gap and during a burst
    run_trace(3, 2, 20, 7, "R8 gap drop");
    run_trace(2, 5, 20, 5, "R8 burst drop");

    for (int k = 0; k < 24; k++)
      run_trace($urandom_range(0, 6), $urandom_range(0, 6), 60, $urandom_range(2, 50), "R2 R3 R4 R5 R8");

    // R7: busy transmitter before first burst and inside a gap (G=3, L=4)
    begin
      int bad = 0;
      bit nh, ej, ee;
      logic [3:0] et;
      jam_gap = 3; jam_len = 4; half_duplex = 1; bp_enable = 1;
      for (int i = 0; i < 26; i++) begin
        nh = (i <= 5) || (i == 14) || (i == 15);
        if (i == 23) bp_enable = 0;
        norm_tx_en = nh;
        norm_txd = 4'($urandom_range(0, 15));
        @(negedge clk);
        ej = (i >= 9 && i <= 12) || (i >= 19 && i <= 22);
        ee = ej || nh;
        et = ej ? 4'h5 : norm_txd;
        if (bad == 0 && (jam_active !== ej || mii_tx_en !== ee || mii_txd !== et)) begin
          bad = 1;
          $display("FAIL R7 cycle %0d: actual jam=%b en=%b txd=%h expected jam=%b en=%b txd=%h",
                   i, jam_active, mii_tx_en, mii_txd, ej, ee, et);
        end
        tick();
      end
      norm_tx_en = 0;
      repeat (10) tick();
      checks++;
      if (bad) errors++;
    end

    // R9: full duplex, enable set, random normal traffic
    begin
      int bad = 0;
      half_duplex = 0; bp_enable = 1; jam_gap = 1; jam_len = 1;
      for (int i = 0; i < 30; i++) begin
        norm_tx_en = 1'($urandom_range(0, 1));
        norm_txd = 4'($urandom_range(0, 15));
        @(negedge clk);
        if (bad == 0 && (jam_active !== 1'b0 || mii_tx_en !== norm_tx_en || mii_txd !== norm_txd)) begin
          bad = 1;
          $display("FAIL R9 full duplex cycle %0d: actual jam=%b en=%b txd=%h expected jam=0 en=%b txd=%h",
                   i, jam_active, mii_tx_en, mii_txd, norm_tx_en, norm_txd);
        end
        tick();
      end
      norm_tx_en = 0; bp_enable = 0;
      repeat (4) tick();
      checks++;
      if (bad) errors++;
    end

    // R9: half duplex dropped mid-burst (G=1, L=6): burst at 2..7, drop at 4, back at 6
    begin
      int bad = 0;
      bit ej;
      jam_gap = 1; jam_len = 6; half_duplex = 1; bp_enable = 1; norm_txd = 4'h0;
      for (int i = 0; i < 10; i++) begin
        if (i == 4) half_duplex = 0;
        if (i == 6) half_duplex = 1;
        @(negedge clk);
        ej = (i >= 2 && i <= 3) || (i >= 8);
        if (bad == 0 && jam_active !== ej) begin
          bad = 1;
          $display("FAIL R9 mid-burst cycle %0d: actual jam=%b expected jam=%b", i, jam_active, ej);
        end
        tick();
      end
      bp_enable = 0;
      repeat (10) tick();
      checks++;
      if (bad) errors++;
    end

    @(negedge clk);
    check1(!jam_active && !mii_tx_en, "R8 idle at end", {jam_active, mii_tx_en}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule